// File: doc/BRIEF.md
# Interrupt Entry and Cycle Sequencer

This block is the per-cycle control sequencer of an 8-bit processor. It keeps a 16-bit state word whose upper byte holds the opcode being executed and whose lower byte counts the cycle within it. State zero is the opcode-fetch cycle. Only there does the block decide whether the next cycle starts a fetched instruction, a reset, a non-maskable entry or a maskable entry. Opcode datapaths and memory are not part of the block. An instruction is modelled as a run of cycle indices whose length comes from the low opcode bits.

Requests come from a reset input, an edge-type non-maskable line and two level-type maskable sources: a video source and a timer source. A free-running 16-bit cycle counter timestamps each request, and a request is accepted only once it is at least two cycles old. The bus-ready input freezes the sequencer while the bus is held by another master. When an entry is chosen, the block presents the vector address with a one-cycle load strobe. A non-maskable entry also produces a one-cycle acknowledge that clears its latch.

Top module: `intr_cycle_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), state_word is 0, instr_done is 1, and vec_load and nmi_ack are 0.
- R2: Suppose the sequencer is in the fetch state with nothing accepted and bus_ready is high. The next state is {opcode_in, 8'h01}. The low byte then rises by one each cycle up to a last index equal to opcode_in[2:0], or 1 when that field is 0. After the last index the state returns to 0.
- R3: While bus_ready is low, state_word holds its value, no entry is chosen, and vec_load and nmi_ack are 0.
- R4: A pulse on reset_req is held pending until the next unstalled fetch. There it wins over every other request: the state stays 0, vec_addr becomes 16'hFFFC, vec_load pulses, and any pending non-maskable request is discarded.
- R5: A pending non-maskable request at an unstalled fetch starts the entry at state 16'h0010, with vec_addr 16'hFFFA. vec_load and nmi_ack are each high for exactly one cycle, and the request is no longer pending afterwards.
- R6: A request is accepted only when (cycle_count − stamp) mod 2^16 ≥ 2. The stamp is the cycle_count value sampled at the edge where the request line was first seen high. A younger request lets an instruction start and is taken at a later fetch. The subtraction wraps modulo 2^16.
- R7: A non-maskable request is latched only on a low-to-high transition of nmi_line. A line that stays high after acceptance does not cause a second entry.
- R8: When irq_disable is 0 and either irq_video or irq_timer has been high for long enough, an unstalled fetch starts the entry at state 16'h0008, with vec_addr 16'hFFFE and a vec_load pulse.
- R9: While irq_disable is 1, the maskable sources have no effect, and the fetch starts an instruction.
- R10: When a non-maskable request and a maskable request are both eligible, the non-maskable entry is taken.
- R11: An entry sequence runs for 7 cycles: 16'h0008 to 16'h000E for maskable, 16'h0010 to 16'h0016 for non-maskable. The state then returns to 0.
- R12: instr_done is 1 exactly when state_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Processor reset request pulse |
| nmi_line | input | 1 | Non-maskable request line (edge sensitive) |
| irq_video | input | 1 | Maskable request from video source (level) |
| irq_timer | input | 1 | Maskable request from timer source (level) |
| irq_disable | input | 1 | Interrupt-disable flag |
| bus_ready | input | 1 | Bus available; low stalls the sequencer |
| cycle_count | input | 16 | Free-running cycle counter |
| opcode_in | input | 8 | Opcode read in the fetch cycle |
| state_word | output | 16 | Current state: opcode in bits 15:8, cycle index in 7:0 |
| vec_addr | output | 16 | Vector address of the last chosen entry |
| vec_load | output | 1 | One-cycle strobe when a vector is chosen |
| nmi_ack | output | 1 | One-cycle acknowledge of a non-maskable entry |
| instr_done | output | 1 | High in the fetch state |

## Verification
Outputs are registered, so an entry decision made at a fetch edge shows up in state_word, vec_addr, vec_load and nmi_ack one edge later. A request becomes eligible two edges after the edge at which its line was first sampled high. The bench drives inputs just after the falling edge and reads outputs at the following falling edge. Each scenario first parks the sequencer at fetch with bus_ready low, then raises bus_ready at a chosen cycle, so the number of edges to the decision is known in advance. Request ages, including the one across the counter wrap, are counted from the cycle_count value the bench supplies.

// File: rtl/intr_seq_pkg.sv
// Shared constants and helpers for the interrupt entry and cycle sequencer.
// Assumes a 16-bit state word: opcode in the upper byte, cycle index below.
package intr_seq_pkg;
    localparam int unsigned STATE_W      = 16;
    localparam int unsigned OPC_W        = 8;
    localparam int unsigned ENTRY_CYCLES = 7;

    localparam logic [STATE_W-1:0] ST_FETCH    = 16'h0000;
    localparam logic [STATE_W-1:0] ST_IRQ_BASE = 16'h0008;
    localparam logic [STATE_W-1:0] ST_NMI_BASE = 16'h0010;

    localparam logic [15:0] VEC_RESET = 16'hFFFC;
    localparam logic [15:0] VEC_NMI   = 16'hFFFA;
    localparam logic [15:0] VEC_IRQ   = 16'hFFFE;

    // Last state word of the stub instruction run for a given opcode.
    function automatic logic [STATE_W-1:0] instr_last(input logic [OPC_W-1:0] opc);
        logic [2:0] idx;
        idx = (opc[2:0] == 3'd0) ? 3'd1 : opc[2:0];
        return {opc, 5'd0, idx};
    endfunction
endpackage

// File: rtl/req_ager.sv
// Request timestamping and age qualification.
// EDGE_LATCH=1: a rising edge of req_line sets a pending bit that stays set
// until clr. EDGE_LATCH=0: the request is pending while the line is high.
// In both variants the stamp is taken on the edge where the line is first
// seen high, and the request counts as aged once
// (cycle_count - stamp) mod 2^CNT_W >= MIN_AGE.
module req_ager #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MIN_AGE    = 2,
    parameter bit          EDGE_LATCH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_line,
    input  logic             clr,
    input  logic [CNT_W-1:0] cycle_count,
    output logic             pending,
    output logic             aged
);
    localparam logic [CNT_W-1:0] AGE_MIN = CNT_W'(MIN_AGE);

    logic             line_q;
    logic [CNT_W-1:0] stamp_q;
    logic [CNT_W-1:0] age;
    logic             rise;

    assign rise = req_line && !line_q;
    assign age  = cycle_count - stamp_q;

    // Track the previous line level and capture the stamp at a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            stamp_q <= '0;
        end else begin
            line_q <= req_line;
            if (rise) stamp_q <= cycle_count;
        end
    end

    generate
        if (EDGE_LATCH) begin : g_edge
            logic pend_q;

            // Pending bit: cleared on acceptance, set by a new rising edge (set wins).
            always_ff @(posedge clk) begin
                if (!rst_n)    pend_q <= 1'b0;
                else if (rise) pend_q <= 1'b1;
                else if (clr)  pend_q <= 1'b0;
            end

            assign pending = pend_q;

            // R7
            nmi_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_q) |-> $past(req_line && !line_q));
        end else begin : g_level
            assign pending = req_line && line_q;
        end
    endgenerate

    assign aged = pending && (age >= AGE_MIN);
endmodule

// File: rtl/seq_core.sv
// Cycle-state register and the decision made at the fetch boundary.
// Assumes that the qualified request inputs are already aged and masked,
// and that bus_ready low stalls every cycle, the decision cycle included.
module seq_core
    import intr_seq_pkg::*;
#(
    parameter int unsigned ENTRY_LEN = ENTRY_CYCLES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ready,
    input  logic               reset_req,
    input  logic               nmi_ok,
    input  logic               irq_ok,
    input  logic [OPC_W-1:0]   opcode_in,
    output logic [STATE_W-1:0] state_q,
    output logic [15:0]        vec_q,
    output logic               vec_load_q,
    output logic               nmi_ack_q,
    output logic               take_reset,
    output logic               take_nmi
);
    localparam logic [STATE_W-1:0] ENTRY_SPAN = STATE_W'(ENTRY_LEN - 1);

    logic               rst_pend_q;
    logic [STATE_W-1:0] last_q;
    logic               at_fetch;
    logic               take_irq;

    assign at_fetch   = bus_ready && (state_q == ST_FETCH);
    assign take_reset = at_fetch && rst_pend_q;
    assign take_nmi   = at_fetch && !rst_pend_q && nmi_ok;
    assign take_irq   = at_fetch && !rst_pend_q && !nmi_ok && irq_ok;

    // Hold a reset request until an unstalled fetch takes it (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_pend_q <= 1'b0;
        else if (reset_req)  rst_pend_q <= 1'b1;
        else if (take_reset) rst_pend_q <= 1'b0;
    end

    // Advance the state word, or choose the next sequence at the fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_FETCH;
            last_q     <= ST_FETCH;
            vec_q      <= VEC_RESET;
            vec_load_q <= 1'b0;
            nmi_ack_q  <= 1'b0;
        end else begin
            vec_load_q <= 1'b0;
            nmi_ack_q  <= 1'b0;
            if (bus_ready) begin
                if (state_q == ST_FETCH) begin
                    if (take_reset) begin
                        state_q    <= ST_FETCH;
                        last_q     <= ST_FETCH;
                        vec_q      <= VEC_RESET;
                        vec_load_q <= 1'b1;
                    end else if (take_nmi) begin
                        state_q    <= ST_NMI_BASE;
                        last_q     <= ST_NMI_BASE + ENTRY_SPAN;
                        vec_q      <= VEC_NMI;
                        vec_load_q <= 1'b1;
                        nmi_ack_q  <= 1'b1;
                    end else if (take_irq) begin
                        state_q    <= ST_IRQ_BASE;
                        last_q     <= ST_IRQ_BASE + ENTRY_SPAN;
                        vec_q      <= VEC_IRQ;
                        vec_load_q <= 1'b1;
                    end else begin
                        state_q <= {opcode_in, 8'h01};
                        last_q  <= instr_last(opcode_in);
                    end
                end else if (state_q == last_q) begin
                    state_q <= ST_FETCH;
                end else begin
                    state_q <= state_q + STATE_W'(1);
                end
            end
        end
    end

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> ($stable(state_q) && !vec_load_q && !nmi_ack_q));

    // R5
    nmi_entry_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack_q |-> (state_q == ST_NMI_BASE && vec_q == VEC_NMI && vec_load_q));

    // R6
    ack_aged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack_q |-> $past(nmi_ok));

    // R2
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[15:8] != 8'h00) |-> (state_q[7:3] == 5'd0 && state_q[2:0] != 3'd0));

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack_q |=> !nmi_ack_q);
endmodule

// File: rtl/intr_cycle_seq.sv
// Top of the interrupt entry and cycle sequencer. It ages the non-maskable
// edge request and the combined maskable level request against a shared
// cycle counter, applies the disable flag, and feeds the fetch-boundary
// decision in seq_core. Assumes that cycle_count advances once per clock.
module intr_cycle_seq
    import intr_seq_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned MIN_AGE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               nmi_line,
    input  logic               irq_video,
    input  logic               irq_timer,
    input  logic               irq_disable,
    input  logic               bus_ready,
    input  logic [CNT_W-1:0]   cycle_count,
    input  logic [OPC_W-1:0]   opcode_in,
    output logic [STATE_W-1:0] state_word,
    output logic [15:0]        vec_addr,
    output logic               vec_load,
    output logic               nmi_ack,
    output logic               instr_done
);
    logic nmi_pend, nmi_aged;
    logic irq_pend, irq_aged;
    logic take_reset, take_nmi;
    logic nmi_clr;

    assign nmi_clr = take_reset || take_nmi;

    req_ager #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .EDGE_LATCH(1'b1)) i_nmi_ager (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_line    (nmi_line),
        .clr         (nmi_clr),
        .cycle_count (cycle_count),
        .pending     (nmi_pend),
        .aged        (nmi_aged)
    );

    req_ager #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .EDGE_LATCH(1'b0)) i_irq_ager (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_line    (irq_video || irq_timer),
        .clr         (1'b0),
        .cycle_count (cycle_count),
        .pending     (irq_pend),
        .aged        (irq_aged)
    );

    seq_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ready  (bus_ready),
        .reset_req  (reset_req),
        .nmi_ok     (nmi_aged),
        .irq_ok     (irq_aged && !irq_disable),
        .opcode_in  (opcode_in),
        .state_q    (state_word),
        .vec_q      (vec_addr),
        .vec_load_q (vec_load),
        .nmi_ack_q  (nmi_ack),
        .take_reset (take_reset),
        .take_nmi   (take_nmi)
    );

    assign instr_done = (state_word == ST_FETCH);

    // R9
    mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_addr == VEC_IRQ) |-> !$past(irq_disable));

    // R10
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_addr == VEC_IRQ) |-> !$past(nmi_aged));

    // R4
    reset_drops_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_reset && !(nmi_line && !$past(nmi_line))) |=> !nmi_pend);

    // R8
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_addr == VEC_IRQ) |-> $past(irq_pend));
endmodule

// File: tb/test_intr_cycle_seq.sv
// Directed bench: one task per scenario. Inputs change just after the
// falling edge, and outputs are read at the next falling edge.
module test_intr_cycle_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0;
    logic        nmi_line = 1'b0;
    logic        irq_video = 1'b0;
    logic        irq_timer = 1'b0;
    logic        irq_disable = 1'b1;
    logic        bus_ready = 1'b0;
    logic [15:0] cycle_count = 16'h0100;
    logic [7:0]  opcode_in = 8'h00;
    logic [15:0] state_word;
    logic [15:0] vec_addr;
    logic        vec_load;
    logic        nmi_ack;
    logic        instr_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_cycle_seq i_intr_cycle_seq (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_line(nmi_line),
        .irq_video(irq_video), .irq_timer(irq_timer), .irq_disable(irq_disable),
        .bus_ready(bus_ready), .cycle_count(cycle_count), .opcode_in(opcode_in),
        .state_word(state_word), .vec_addr(vec_addr), .vec_load(vec_load),
        .nmi_ack(nmi_ack), .instr_done(instr_done)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: through the rising edge to the falling edge, then advance the counter.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycle_count = cycle_count + 16'd1;
    endtask

    // Reset and leave the sequencer parked at fetch with the bus stalled.
    task automatic park();
        reset_req = 0; nmi_line = 0; irq_video = 0; irq_timer = 0;
        irq_disable = 1; bus_ready = 0; rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic t_reset_state();
        park();
        chk("R1 state", state_word, 16'h0000);
        chk("R1 done", {15'd0, instr_done}, 16'd1);
        chk("R1 vec_load", {15'd0, vec_load}, 16'd0);
        chk("R1 nmi_ack", {15'd0, nmi_ack}, 16'd0);
    endtask

    task automatic t_instr_run(input logic [7:0] opc);
        int last;
        park();
        last = (opc[2:0] == 0) ? 1 : int'(opc[2:0]);
        opcode_in = opc; bus_ready = 1;
        for (int i = 1; i <= last; i++) begin
            tick();
            chk("R2 step", state_word, {opc, 8'(i)});
            chk("R12 busy", {15'd0, instr_done}, 16'd0);
        end
        tick();
        chk("R2 return", state_word, 16'h0000);
        chk("R12 done", {15'd0, instr_done}, 16'd1);
    endtask

    task automatic t_stall();
        park();
        opcode_in = 8'h05; bus_ready = 1;
        tick();
        chk("R3 first", state_word, 16'h0501);
        bus_ready = 0;
        tick(); tick();
        chk("R3 hold", state_word, 16'h0501);
        bus_ready = 1;
        tick();
        chk("R3 resume", state_word, 16'h0502);
        park();
        nmi_line = 1;
        tick(); tick(); tick(); tick();
        chk("R3 fetch stalled", state_word, 16'h0000);
        chk("R3 no vec_load", {15'd0, vec_load}, 16'd0);
        chk("R3 no ack", {15'd0, nmi_ack}, 16'd0);
    endtask

    task automatic t_nmi_entry();
        park();
        opcode_in = 8'h03; nmi_line = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R5 state", state_word, 16'h0010);
        chk("R5 vec", vec_addr, 16'hFFFA);
        chk("R5 vec_load", {15'd0, vec_load}, 16'd1);
        chk("R5 ack", {15'd0, nmi_ack}, 16'd1);
        for (int i = 1; i < 7; i++) begin
            tick();
            chk("R11 nmi seq", state_word, 16'h0010 + 16'(i));
            if (i == 1) begin
                chk("R5 ack one cycle", {15'd0, nmi_ack}, 16'd0);
                chk("R5 load one cycle", {15'd0, vec_load}, 16'd0);
            end
        end
        tick();
        chk("R11 nmi end", state_word, 16'h0000);
        tick();
        chk("R7 held line no retrigger", state_word, 16'h0301);
    endtask

    task automatic t_nmi_young();
        park();
        opcode_in = 8'h03; nmi_line = 1;
        tick();
        bus_ready = 1;
        tick();
        chk("R6 young -> instr", state_word, 16'h0301);
        chk("R6 no ack", {15'd0, nmi_ack}, 16'd0);
        tick(); tick(); tick();
        chk("R6 back to fetch", state_word, 16'h0000);
        tick();
        chk("R6 taken later", state_word, 16'h0010);
    endtask

    task automatic t_nmi_edge();
        park();
        opcode_in = 8'h01; nmi_line = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R7 first edge", state_word, 16'h0010);
        nmi_line = 0;
        for (int i = 0; i < 7; i++) tick();
        chk("R7 at fetch", state_word, 16'h0000);
        nmi_line = 1;
        bus_ready = 0;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R7 second edge", state_word, 16'h0010);
    endtask

    task automatic t_wrap();
        park();
        cycle_count = 16'hFFFE; nmi_line = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R6 wrap age", state_word, 16'h0010);
    endtask

    task automatic t_reset_priority();
        park();
        opcode_in = 8'h02; nmi_line = 1; reset_req = 1;
        tick();
        reset_req = 0;
        tick();
        bus_ready = 1;
        tick();
        chk("R4 state", state_word, 16'h0000);
        chk("R4 vec", vec_addr, 16'hFFFC);
        chk("R4 vec_load", {15'd0, vec_load}, 16'd1);
        chk("R4 no ack", {15'd0, nmi_ack}, 16'd0);
        tick();
        chk("R4 nmi discarded", state_word, 16'h0201);
    endtask

    task automatic t_irq(input bit use_video);
        park();
        irq_disable = 0;
        if (use_video) irq_video = 1; else irq_timer = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R8 state", state_word, 16'h0008);
        chk("R8 vec", vec_addr, 16'hFFFE);
        chk("R8 vec_load", {15'd0, vec_load}, 16'd1);
        chk("R8 no ack", {15'd0, nmi_ack}, 16'd0);
        irq_video = 0; irq_timer = 0;
        for (int i = 1; i < 7; i++) begin
            tick();
            chk("R11 irq seq", state_word, 16'h0008 + 16'(i));
        end
        tick();
        chk("R11 irq end", state_word, 16'h0000);
    endtask

    task automatic t_irq_masked();
        park();
        opcode_in = 8'h01; irq_disable = 1; irq_video = 1; irq_timer = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R9 masked -> instr", state_word, 16'h0101);
        chk("R9 no vec_load", {15'd0, vec_load}, 16'd0);
    endtask

    task automatic t_priority();
        park();
        irq_disable = 0; irq_timer = 1; nmi_line = 1;
        tick(); tick();
        bus_ready = 1;
        tick();
        chk("R10 nmi wins", state_word, 16'h0010);
        chk("R10 vec", vec_addr, 16'hFFFA);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_instr_run(8'h00);
        t_instr_run(8'h03);
        t_instr_run(8'h07);
        t_stall();
        t_nmi_entry();
        t_nmi_young();
        t_nmi_edge();
        t_wrap();
        t_reset_priority();
        t_irq(1'b1);
        t_irq(1'b0);
        t_irq_masked();
        t_priority();
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule